// File: doc/BRIEF.md
# Freezable Angle Output Port with Byte Enables

This block sits between a tracking converter's continuously updated angle value and an 8-bit host bus. It compares the incoming tracking value with the word it last settled on. When the two differ, it raises a busy pulse of fixed length and commits the new value halfway through that pulse. The committed word reaches the host through an output latch. The latch is transparent until the host pulls the active-low inhibit line. The host then reads the held word one byte at a time by pulling one of two active-low byte enables. When neither enable is pulled, the bus driver is turned off.

Inhibit never stops tracking. Busy pulses and internal updates go on while the latch is held. If inhibit arrives while a busy pulse is running, the latch waits until the pulse has ended before it captures. The captured word is therefore always a completed update, and the host never has to watch the busy line. An external pad drives the bus pins from `bus_data` whenever `bus_oe` is high.

Top module: `angle_out_port`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `busy_o`, `word_o`, `bus_oe`, `bus_data` and `bus_clash` are all zero.
- R2: When `busy_o` is low and `trk_angle` differs from the settled word at a clock edge, `busy_o` is high for exactly BUSY_CYC cycles (default 4), starting with the cycle after that edge. A change that arrives during a pulse starts a new pulse after the current one ends.
- R3: The new value appears on `word_o` when the latch is transparent. It appears in busy cycle BUSY_CYC/2, counting the cycles of the pulse from 0, and not earlier.
- R4: While `inh_n` is high, `word_o` follows the settled word. In the cycle after `inh_n` returns high, `word_o` shows the current settled word again.
- R5: If `inh_n` is low while `busy_o` is low, `word_o` is held from the next cycle on. Busy pulses and updates to the settled word continue in the meantime.
- R6: If `inh_n` goes low while `busy_o` is high, the capture waits until `busy_o` is low. The held word is the value committed by that pulse.
- R7: The byte enables are registered, so their effect appears one cycle later. When `en_hi_n` is low, `bus_oe` is high and `bus_data` carries `word_o[15:8]`. When only `en_lo_n` is low, `bus_data` carries `word_o[7:0]`.
- R8: When both enables are low, `bus_data` carries the high byte and `bus_clash` is high one cycle later.
- R9: When both enables are high, `bus_oe`, `bus_clash` and `bus_data` are zero one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trk_angle | input | 16 | Tracking value from the converter loop |
| inh_n | input | 1 | Freeze request for the output latch, active low |
| en_hi_n | input | 1 | High-byte enable, active low |
| en_lo_n | input | 1 | Low-byte enable, active low |
| busy_o | output | 1 | Update-in-progress pulse |
| word_o | output | 16 | Output latch contents |
| bus_oe | output | 1 | Bus driver enable for the pad |
| bus_data | output | 8 | Byte to drive, zero when not enabled |
| bus_clash | output | 1 | Both enables were low |

## Verification
A busy counter in the wrong state shows up at once as a pulse of the wrong length on `busy_o`. It also moves the point in the pulse where `word_o` changes, and the bench checks that point cycle by cycle. A freeze flag that sets too early or too late leaves the wrong word in the latch. This shows on `word_o` within one pulse length after inhibit falls, and it stays visible for as long as inhibit is held. A bad enable register shows on `bus_oe` and `bus_data` one cycle after the enables change.

// File: rtl/angle_out_port.sv
module angle_out_port #(
  parameter int BYTE_W   = 8,
  parameter int BUSY_CYC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*BYTE_W-1:0] trk_angle,
  input  logic                inh_n,
  input  logic                en_hi_n,
  input  logic                en_lo_n,
  output logic                busy_o,
  output logic [2*BYTE_W-1:0] word_o,
  output logic                bus_oe,
  output logic [BYTE_W-1:0]   bus_data,
  output logic                bus_clash
);
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int CNT_W   = $clog2(BUSY_CYC + 1);
  localparam int MID_CNT = BUSY_CYC - BUSY_CYC / 2 + 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] settled_q, pend_q, held_q;
  logic              frz_q, sel_hi_q;
  logic              start;

  assign busy_o = (cnt_q != '0);
  assign start  = !busy_o && (trk_angle != settled_q);
  assign word_o = frz_q ? held_q : settled_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pend_q    <= '0;
      settled_q <= '0;
    end else begin
      if (start) begin
        cnt_q  <= CNT_W'(BUSY_CYC);
        pend_q <= trk_angle;
      end else if (busy_o) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (cnt_q == CNT_W'(MID_CNT))
        settled_q <= pend_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frz_q  <= 1'b0;
      held_q <= '0;
    end else if (inh_n) begin
      frz_q <= 1'b0;
    end else if (!frz_q && !busy_o) begin
      frz_q  <= 1'b1;
      held_q <= settled_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_oe    <= 1'b0;
      sel_hi_q  <= 1'b0;
      bus_clash <= 1'b0;
    end else begin
      bus_oe    <= !(en_hi_n && en_lo_n);
      sel_hi_q  <= !en_hi_n;
      bus_clash <= !en_hi_n && !en_lo_n;
    end
  end

  assign bus_data = !bus_oe  ? '0 :
                    sel_hi_q ? word_o[WORD_W-1:BYTE_W] : word_o[BYTE_W-1:0];
endmodule

module angle_out_port_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy_o,
  input logic                frz_q,
  input logic [2*BYTE_W-1:0] word_o,
  input logic                bus_oe,
  input logic [BYTE_W-1:0]   bus_data,
  input logic                bus_clash
);
  // R3
  mid_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz_q && !$past(frz_q) && !$stable(word_o)) |-> busy_o);
  // R6
  capture_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frz_q) |-> !$past(busy_o));
  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && $past(frz_q)) |-> $stable(word_o));
  // R8
  clash_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clash |-> (bus_oe && bus_data == word_o[2*BYTE_W-1:BYTE_W]));
  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_data == '0 && !bus_clash));
endmodule

bind angle_out_port angle_out_port_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .frz_q(frz_q), .word_o(word_o),
  .bus_oe(bus_oe), .bus_data(bus_data), .bus_clash(bus_clash)
);

// File: tb/angle_out_port_tb.sv
module angle_out_port_tb_top;
  localparam int BUSY_CYC = 4;
  localparam int NVEC = 5;
  // {en_hi_n, en_lo_n, exp_oe, exp_clash, exp_hi}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b11_0_0_0, 5'b01_1_0_1, 5'b10_1_0_0, 5'b00_1_1_1, 5'b11_0_0_0};

  logic clk = 0, rst_n = 0, inh_n = 1, en_hi_n = 1, en_lo_n = 1;
  logic [15:0] trk_angle = '0;
  logic busy_o, bus_oe, bus_clash;
  logic [15:0] word_o;
  logic [7:0] bus_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  angle_out_port #(.BYTE_W(8), .BUSY_CYC(BUSY_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .trk_angle(trk_angle), .inh_n(inh_n),
    .en_hi_n(en_hi_n), .en_lo_n(en_lo_n), .busy_o(busy_o), .word_o(word_o),
    .bus_oe(bus_oe), .bus_data(bus_data), .bus_clash(bus_clash));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_reset_state();
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 word", 32'(word_o), 0);
    chk("R1 oe", 32'(bus_oe), 0);
    chk("R1 data", 32'(bus_data), 0);
    chk("R1 clash", 32'(bus_clash), 0);
  endtask

  initial begin
    int bc, first, seen;
    tick(); tick();
    chk_reset_state();
    rst_n = 1;
    tick();
    chk_reset_state();

    // R2 / R3: pulse length and mid-pulse commit
    trk_angle = 16'h1234;
    bc = 0; first = -1;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (busy_o) bc++;
      if (first < 0 && word_o == 16'h1234) first = i;
    end
    chk("R2 busy width", 32'(bc), BUSY_CYC);
    chk("R3 commit cycle", 32'(first), BUSY_CYC / 2);
    chk("R4 transparent", 32'(word_o), 16'h1234);

    // R5: inhibit while idle; tracking continues
    inh_n = 0; trk_angle = 16'h1235;
    bc = 0; seen = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (busy_o) bc++;
      if (word_o != 16'h1234) seen = 1;
    end
    chk("R5 held word", 32'(seen), 0);
    chk("R5 tracking continues", 32'(bc), BUSY_CYC);
    inh_n = 1;
    tick();
    chk("R4 release", 32'(word_o), 16'h1235);

    // R6: inhibit during busy waits for the pulse to end
    trk_angle = 16'h2000;
    tick();
    chk("R2 pulse start", 32'(busy_o), 1);
    inh_n = 0; trk_angle = 16'h2001;
    for (int i = 0; i < 12; i++) tick();
    chk("R6 deferred capture", 32'(word_o), 16'h2000);
    inh_n = 1;
    tick();
    chk("R4 release after deferred", 32'(word_o), 16'h2001);

    // R7 / R8 / R9: byte enable table
    for (int v = 0; v < NVEC; v++) begin
      logic [4:0] e;
      e = VEC[v];
      en_hi_n = e[4]; en_lo_n = e[3];
      tick();
      chk("R7 oe", 32'(bus_oe), 32'(e[2]));
      chk("R8 clash", 32'(bus_clash), 32'(e[1]));
      chk("R9/R7 data", 32'(bus_data),
          !e[2] ? 0 : (e[0] ? 32'h20 : 32'h01));
    end

    // R1: reset in mid-run
    en_lo_n = 0; trk_angle = 16'h0777;
    tick();
    rst_n = 0; trk_angle = '0; en_lo_n = 1;
    tick();
    chk_reset_state();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule